// File: doc/BRIEF.md
# Indirect Register Access Bridge

The bridge lets a host reach up to 64 internal core registers through only two host-visible registers. The first is a control register that holds the target index, an auto-fetch enable and a fetch-pending flag. The second is a data window. A read is requested by setting the pending flag. The bridge then runs a request/acknowledge exchange with the slower core side and drops the flag in the same cycle the fetched value lands in the data window.

Writes go the other way. A host write to the data window while no fetch is pending is passed to the core as a one-cycle write request at the current index. With auto-fetch enabled, every host read of the data window starts the next fetch from the same index. This lets the host drain a FIFO-style core register by reading the window over and over.

Top module: `irb_bridge`

## Requirements
- R1: After reset the control register reads 0x00, the data window reads 0x00 and `core_req` is low.
- R2: A read of the control register (`host_sel`=0) returns the index in bits 5..0, auto-fetch in bit 6 and the live pending flag in bit 7. A control write loads bits 5..0 and bit 6.
- R3: A control write with bit 7 = 1 while no fetch is pending starts a fetch at the index carried by that same write. From the next cycle `core_req`=1, `core_we`=0 and `core_addr` equals that index.
- R4: A control write with bit 7 = 0 starts no fetch.
- R5: The pending flag reads 1 from the cycle after the start until the cycle after `core_ack`. At the `core_ack` edge `core_rdata` is captured into the data window and the flag clears.
- R6: While a fetch is outstanding, `core_req` stays high with `core_we`=0 and a stable `core_addr` until acknowledged. Neither a start request nor an index change written during that time alters the outstanding fetch. The start request is dropped.
- R7: With auto-fetch = 1 and no fetch pending, a host read of the data window (`host_sel`=1, `host_rd`=1) starts a fetch at the unchanged index.
- R8: With auto-fetch = 0, a host read of the data window starts no fetch.
- R9: A host write to the data window while no fetch is pending drives `core_req`=1, `core_we`=1, `core_addr` = current index and `core_wdata` = written value for exactly the next cycle.
- R10: A host write to the data window while a fetch is pending is dropped: no core write is issued.
- R11: A read of the data window returns the last fetched value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (acts only on the data window) |
| host_sel | input | 1 | 0 = control register, 1 = data window |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Selected register contents |
| core_req | output | 1 | Core request (read held until ack, write one cycle) |
| core_we | output | 1 | 1 = core write request |
| core_addr | output | 6 | Core register index |
| core_wdata | output | 8 | Core write data |
| core_ack | input | 1 | Core read acknowledge, one cycle |
| core_rdata | input | 8 | Core read data, valid with `core_ack` |

## Verification
The bench varies the core latency from one to eight cycles. A design that cleared the pending flag one cycle early or late, or captured data outside the acknowledge edge, would show a stale window value or a wrong flag. A control write that changes the index while also requesting a start shows whether the fetch uses the new index or the old one. Start requests and window writes made back to back with a pending fetch show whether either leaks onto the core bus. Auto-fetch draining is checked with the mode both on and off, to catch a design that re-arms the fetch when it should not, or fails to re-arm it when it should.

// File: rtl/irb_pkg.sv
package irb_pkg;
    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_DATA = 1'b1
    } irb_sel_e;
endpackage

// File: rtl/irb_hostregs.sv
module irb_hostregs #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic              host_sel,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              rd_done,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_start,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_start,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              busy
);
    import irb_pkg::*;

    localparam int AUTO_BIT = ADDR_W;
    localparam int BUSY_BIT = ADDR_W + 1;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              auto_rd;
        logic              busy;
        logic [DATA_W-1:0] data;
    } regs_t;

    regs_t st_d, st_q;
    logic  ctrl_wr, data_wr, data_rd, launch;
    logic [DATA_W-1:0] ctrl_view;

    always_comb begin
        st_d     = st_q;
        ctrl_wr  = host_wr && (host_sel == SEL_CTRL);
        data_wr  = host_wr && (host_sel == SEL_DATA);
        data_rd  = host_rd && !host_wr && (host_sel == SEL_DATA);
        launch   = !st_q.busy &&
                   ((ctrl_wr && host_wdata[BUSY_BIT]) || (data_rd && st_q.auto_rd));
        rd_addr  = ctrl_wr ? host_wdata[ADDR_W-1:0] : st_q.addr;
        wr_start = data_wr && !st_q.busy;
        rd_start = launch;

        if (rd_done) begin
            st_d.data = rd_data;
            st_d.busy = 1'b0;
        end
        if (ctrl_wr) begin
            st_d.addr    = host_wdata[ADDR_W-1:0];
            st_d.auto_rd = host_wdata[AUTO_BIT];
        end
        if (launch) begin
            st_d.busy = 1'b1;
        end

        ctrl_view                = '0;
        ctrl_view[ADDR_W-1:0]    = st_q.addr;
        ctrl_view[AUTO_BIT]      = st_q.auto_rd;
        ctrl_view[BUSY_BIT]      = st_q.busy;
        host_rdata = (host_sel == SEL_CTRL) ? ctrl_view : st_q.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_addr = st_q.addr;
    assign busy     = st_q.busy;

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy && !rd_done |=> st_q.busy);

    // R5
    busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !st_q.busy && (st_q.data == $past(rd_data)));

    // R11
    data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_done |=> $stable(st_q.data));
endmodule

// File: rtl/irb_corelink.sv
module irb_corelink #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_start,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_start,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              core_req,
    output logic              core_we,
    output logic [ADDR_W-1:0] core_addr,
    output logic [DATA_W-1:0] core_wdata,
    input  logic              core_ack,
    input  logic [DATA_W-1:0] core_rdata,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        logic              rd_pend;
        logic [ADDR_W-1:0] rd_addr;
        logic              wr_pend;
        logic [ADDR_W-1:0] wr_addr;
        logic [DATA_W-1:0] wr_data;
    } link_t;

    link_t lk_d, lk_q;

    always_comb begin
        lk_d         = lk_q;
        lk_d.wr_pend = wr_start;
        if (wr_start) begin
            lk_d.wr_addr = wr_addr;
            lk_d.wr_data = wr_data;
        end
        if (lk_q.rd_pend && core_ack) begin
            lk_d.rd_pend = 1'b0;
        end
        if (rd_start) begin
            lk_d.rd_pend = 1'b1;
            lk_d.rd_addr = rd_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= '0;
        else        lk_q <= lk_d;
    end

    assign core_req   = lk_q.rd_pend || lk_q.wr_pend;
    assign core_we    = lk_q.wr_pend;
    assign core_addr  = lk_q.wr_pend ? lk_q.wr_addr : lk_q.rd_addr;
    assign core_wdata = lk_q.wr_data;
    assign rd_done    = lk_q.rd_pend && core_ack;
    assign rd_data    = core_rdata;

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_q.rd_pend && !core_ack |=> core_req && !core_we && $stable(core_addr));

    // R6
    ack_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_ack |-> core_req && !core_we);
endmodule

// File: rtl/irb_bridge.sv
module irb_bridge #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic              host_sel,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              core_req,
    output logic              core_we,
    output logic [ADDR_W-1:0] core_addr,
    output logic [DATA_W-1:0] core_wdata,
    input  logic              core_ack,
    input  logic [DATA_W-1:0] core_rdata
);
    logic              rd_start, wr_start, rd_done, busy;
    logic [ADDR_W-1:0] rd_addr, cur_addr;
    logic [DATA_W-1:0] rd_data;

    irb_hostregs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .rd_done    (rd_done),
        .rd_data    (rd_data),
        .rd_start   (rd_start),
        .rd_addr    (rd_addr),
        .wr_start   (wr_start),
        .cur_addr   (cur_addr),
        .busy       (busy)
    );

    irb_corelink #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_start   (rd_start),
        .rd_addr    (rd_addr),
        .wr_start   (wr_start),
        .wr_addr    (cur_addr),
        .wr_data    (host_wdata),
        .core_req   (core_req),
        .core_we    (core_we),
        .core_addr  (core_addr),
        .core_wdata (core_wdata),
        .core_ack   (core_ack),
        .core_rdata (core_rdata),
        .rd_done    (rd_done),
        .rd_data    (rd_data)
    );

    // R6
    busy_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> core_req && !core_we);

    // R10
    no_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !core_we);

    // R3
    start_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> core_req && !core_we);
endmodule

// File: tb/sim_irb_bridge.sv
module sim_irb_bridge;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       h_wr = 1'b0, h_rd = 1'b0, h_sel = 1'b0;
    logic [7:0] h_wdata = '0;
    logic [7:0] host_rdata;
    logic       core_req, core_we;
    logic [5:0] core_addr;
    logic [7:0] core_wdata;
    logic       core_ack = 1'b0;
    logic [7:0] core_rdata = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irb_bridge u0 (
        .clk(clk), .rst_n(rst_n),
        .host_wr(h_wr), .host_rd(h_rd), .host_sel(h_sel), .host_wdata(h_wdata),
        .host_rdata(host_rdata),
        .core_req(core_req), .core_we(core_we), .core_addr(core_addr),
        .core_wdata(core_wdata), .core_ack(core_ack), .core_rdata(core_rdata)
    );

    function automatic logic [7:0] init_val(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Core register bank model with varying latency
    logic [7:0] bank [64];
    int lat_cnt = 0, lat_sel = 0, wr_seen = 0;
    initial for (int i = 0; i < 64; i++) bank[i] = init_val(i);

    always @(posedge clk) begin
        #1;
        core_ack = 1'b0;
        if (core_req && core_we) begin
            bank[core_addr] = core_wdata;
            wr_seen++;
        end
        if (core_req && !core_we) begin
            lat_cnt++;
            if (lat_cnt >= ((lat_sel * 5) % 8) + 1) begin
                core_ack   = 1'b1;
                core_rdata = bank[core_addr];
                lat_cnt    = 0;
                lat_sel++;
            end
        end else begin
            lat_cnt = 0;
        end
    end

    // Cycle-by-cycle reference model
    logic [5:0] m_addr = '0, m_rdaddr = '0, m_wraddr = '0, o_addr;
    logic       m_auto = 0, m_busy = 0, m_rdreq = 0, m_wr = 0, o_busy, o_auto;
    logic [7:0] m_data = '0, m_wrdata = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_addr = '0; m_auto = 0; m_busy = 0; m_rdreq = 0; m_wr = 0; m_data = '0;
        end else begin
            o_busy = m_busy; o_auto = m_auto; o_addr = m_addr;
            m_wr = 0;
            if (core_ack && m_rdreq) begin
                m_data = core_rdata; m_busy = 0; m_rdreq = 0;
            end
            if (h_wr && !h_sel) begin
                m_addr = h_wdata[5:0];
                m_auto = h_wdata[6];
                if (h_wdata[7] && !o_busy) begin
                    m_busy = 1; m_rdreq = 1; m_rdaddr = h_wdata[5:0];
                end
            end
            if (h_wr && h_sel && !o_busy) begin
                m_wr = 1; m_wraddr = o_addr; m_wrdata = h_wdata;
            end
            if (h_rd && !h_wr && h_sel && o_auto && !o_busy) begin
                m_busy = 1; m_rdreq = 1; m_rdaddr = o_addr;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (!h_sel) chk("R2 ctrl view", host_rdata, {m_busy, m_auto, m_addr});
            else        chk("R11 data view", host_rdata, m_data);
            chk("R6 core_req", core_req, m_rdreq | m_wr);
            chk("R9 core_we", core_we, m_wr);
            if (m_rdreq | m_wr) chk("R6 core_addr", core_addr, m_wr ? m_wraddr : m_rdaddr);
            if (m_wr) chk("R9 core_wdata", core_wdata, m_wrdata);
        end
    end

    task automatic drive(input bit wr, input bit rd, input bit sel, input logic [7:0] d);
        @(posedge clk); #2;
        h_wr = wr; h_rd = rd; h_sel = sel; h_wdata = d;
        @(posedge clk); #2;
        h_wr = 0; h_rd = 0; h_sel = 0;
    endtask

    task automatic drive_two(input logic [7:0] d0, input bit sel1, input logic [7:0] d1);
        @(posedge clk); #2;
        h_wr = 1; h_rd = 0; h_sel = 0; h_wdata = d0;
        @(posedge clk); #2;
        h_sel = sel1; h_wdata = d1;
        @(posedge clk); #2;
        h_wr = 0; h_sel = 0;
    endtask

    task automatic wait_idle;
        bit idle = 0;
        for (int n = 0; n < 20 && !idle; n++) begin
            @(negedge clk);
            if (host_rdata[7] == 1'b0) idle = 1;
        end
        chk("R5 flag cleared", idle, 1);
    endtask

    task automatic read_data(input bit strobe, output logic [7:0] v);
        @(posedge clk); #2;
        h_sel = 1; h_rd = strobe;
        @(negedge clk);
        v = host_rdata;
        @(posedge clk); #2;
        h_sel = 0; h_rd = 0;
    endtask

    initial begin
        logic [7:0] v;
        int ws;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ctrl reset", host_rdata, 8'h00);
        chk("R1 req reset", core_req, 0);
        read_data(0, v);
        chk("R1 data reset", v, 8'h00);

        // R3: start with index in same write
        drive(1, 0, 0, 8'h85);
        @(negedge clk);
        chk("R3 req", core_req, 1);
        chk("R3 we", core_we, 0);
        chk("R3 addr", core_addr, 6'd5);
        chk("R5 flag set", host_rdata[7], 1);
        wait_idle();
        read_data(0, v);
        chk("R5 captured", v, init_val(5));

        // R4: flag bit 0 starts nothing
        drive(1, 0, 0, 8'h0A);
        @(negedge clk);
        chk("R4 no req", core_req, 0);
        chk("R4 ctrl", host_rdata, 8'h0A);

        // R6: restart and index change while pending
        drive_two(8'hBF, 0, 8'h81);
        wait_idle();
        read_data(0, v);
        chk("R6 outstanding kept", v, init_val(63));
        @(negedge clk);
        chk("R6 index updated", host_rdata, 8'h01);

        // R9: data write at idle
        drive(1, 0, 0, 8'h10);
        drive(1, 0, 1, 8'h5A);
        @(negedge clk);
        chk("R9 we", core_we, 1);
        chk("R9 addr", core_addr, 6'h10);
        chk("R9 wdata", core_wdata, 8'h5A);
        @(negedge clk);
        chk("R9 single cycle", core_req, 0);
        drive(1, 0, 0, 8'h90);
        wait_idle();
        read_data(0, v);
        chk("R9 written value", v, 8'h5A);

        // R10: data write while pending
        ws = wr_seen;
        drive_two(8'hA0, 1, 8'hC3);
        wait_idle();
        drive(1, 0, 0, 8'hA0);
        wait_idle();
        read_data(0, v);
        chk("R10 no core write", wr_seen, ws);
        chk("R10 bank intact", v, init_val(32));

        // R7: auto-fetch
        drive(1, 0, 0, 8'hC7);
        wait_idle();
        read_data(1, v);
        chk("R11 read value", v, init_val(7));
        @(negedge clk);
        chk("R7 auto req", core_req, 1);
        chk("R7 auto addr", core_addr, 6'd7);
        chk("R7 index unchanged", host_rdata[5:0], 6'd7);
        wait_idle();
        drive(1, 0, 1, 8'h99);
        read_data(1, v);
        chk("R7 old value", v, init_val(7));
        wait_idle();
        read_data(0, v);
        chk("R7 refetched", v, 8'h99);

        // R8: auto off
        drive(1, 0, 0, 8'h07);
        read_data(1, v);
        @(negedge clk);
        chk("R8 no req", core_req, 0);
        chk("R8 flag", host_rdata[7], 0);

        // R3 sweep across latencies
        for (int a = 0; a < 16; a++) begin
            drive(1, 0, 0, 8'h80 | 8'(a * 4 + 2));
            wait_idle();
            read_data(0, v);
            chk("R3 sweep", v, init_val(a * 4 + 2));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL R5 watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule